// File: doc/BRIEF.md
# Luma and Chroma Output Rounding and Ranging Stage

This stage sits after the decimating filters of a colour space converter and turns their wide fixed-point results into 8-bit pixel bytes. It receives one luma word and two chroma words per cycle, each a signed word with 15 integer bits and 3 fractional bits. For each word it picks the integer field that matters, rounds it using the next lower bit, and saturates it to the 8-bit output range: unsigned 0..255 for luma, signed -128..+127 for chroma.

Three control inputs set the output format. `ctl_norm` selects which chroma field is kept (normalised chroma at one scale, full-range chroma at twice that scale). `ctl_bypass` either sends the clipped values straight out (chroma as two's complement) or routes them through an offset and range stage. In that stage chroma is shifted into offset binary and both kinds of sample are limited to a legal video range. `ctl_sel` then picks either the wide 1..254 range for all three channels, or the studio ranges 16..235 for luma and 16..240 for chroma. One register stage holds the result, and a valid flag is delayed with it.

Top module: `pix_out_formatter`

## Requirements
- R1: Luma output with `ctl_bypass`=1: input bits [12:3] are taken as a 10-bit signed integer, one is added when bit [2] is 1, and the sum saturates to 0..255 with no wraparound.
- R2: Chroma with `ctl_norm`=1: input bits [11:3] are taken as a 9-bit signed integer and one is added when bit [2] is 1.
- R3: Chroma with `ctl_norm`=0: input bits [12:4] are taken as a 9-bit signed integer and one is added when bit [3] is 1.
- R4: The rounded chroma value saturates to -128..+127 with no wraparound. With `ctl_bypass`=1 it leaves as an 8-bit two's complement byte.
- R5: With `ctl_bypass`=0, 128 is added to each clipped chroma value, which gives offset binary, before range limiting.
- R6: With `ctl_bypass`=0 and `ctl_sel`=1, luma and both chroma outputs are limited to 1..254.
- R7: With `ctl_bypass`=0 and `ctl_sel`=0, luma is limited to 16..235 and each chroma output to 16..240.
- R8: Outputs change only at a rising clock edge, one cycle after their inputs are presented. `out_valid` equals `in_valid` delayed by that same one cycle.
- R9: While `rst_n` is low, `out_valid` and all pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input words are valid this cycle |
| ctl_norm | input | 1 | 1: normalised chroma field, 0: full-range chroma field |
| ctl_sel | input | 1 | 1: wide range 1..254, 0: studio ranges |
| ctl_bypass | input | 1 | 1: no offset or ranging, 0: chroma offset and range limiting |
| luma_in | input | 18 | Luma filter output, signed, 3 fractional bits |
| cha_in | input | 18 | First chroma filter output, signed, 3 fractional bits |
| chb_in | input | 18 | Second chroma filter output, signed, 3 fractional bits |
| out_valid | output | 1 | The registered outputs are valid |
| luma_out | output | 8 | Luma byte, unsigned |
| cha_out | output | 8 | First chroma byte |
| chb_out | output | 8 | Second chroma byte |

## Verification
The rounding carry and the saturation or range clamp can both act on the same sample. This happens when a value sits half a step below a limit. Luma 254.5 rounds to 255 and must then come out as 254 or 235, depending on the range setting. Chroma 127.5 rounds to 128, must saturate to 127, and after the offset must clamp to 254 or 240. The directed tests drive these half-step inputs in every control combination and compare the registered bytes with a reference model computed from the requirements. The overflow sums of 511.5 in luma and 255 in full-range chroma show whether the carry was allowed to wrap before the clip.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;

   typedef enum logic [1:0] {
      LIM_NONE   = 2'd0,
      LIM_WIDE   = 2'd1,
      LIM_STUDIO = 2'd2
   } limit_kind_e;

   function automatic limit_kind_e pick_limit(input logic bypass, input logic sel);
      if (bypass)   return LIM_NONE;
      else if (sel) return LIM_WIDE;
      else          return LIM_STUDIO;
   endfunction

endpackage

// File: rtl/luma_round_clip.sv
module luma_round_clip #(
   parameter int IN_INT_W  = 15,
   parameter int IN_FRAC_W = 3,
   parameter int PIX_W     = 8
) (
   input  logic [IN_INT_W+IN_FRAC_W-1:0] din,
   output logic [PIX_W-1:0]              dout
);
   localparam int IN_W   = IN_INT_W + IN_FRAC_W;
   localparam int KEEP_W = PIX_W + 2;
   localparam int SUM_W  = KEEP_W + 1;
   localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((2 ** PIX_W) - 1);

   if (IN_INT_W < KEEP_W) begin : g_bad_int
      $error("luma_round_clip: IN_INT_W too small for the kept field");
   end
   if (IN_FRAC_W < 1) begin : g_bad_frac
      $error("luma_round_clip: at least one fractional bit is needed");
   end

   logic signed [KEEP_W-1:0] fld;
   logic                     rnd_bit;
   logic signed [SUM_W-1:0]  sum;
   logic                     unused_bits;

   assign fld         = din[IN_FRAC_W +: KEEP_W];
   assign rnd_bit     = din[IN_FRAC_W-1];
   assign sum         = {fld[KEEP_W-1], fld} + SUM_W'(rnd_bit);
   assign unused_bits = ^{din, IN_W'(0)};

   always_comb begin
      if (sum < 0)          dout = '0;
      else if (sum > MAX_V) dout = '1;
      else                  dout = sum[PIX_W-1:0];
   end
endmodule

// File: rtl/chroma_round_clip.sv
module chroma_round_clip #(
   parameter int IN_INT_W  = 15,
   parameter int IN_FRAC_W = 3,
   parameter int PIX_W     = 8
) (
   input  logic [IN_INT_W+IN_FRAC_W-1:0] din,
   input  logic                          norm,
   output logic [PIX_W-1:0]              dout
);
   localparam int KEEP_W = PIX_W + 1;
   localparam int SUM_W  = KEEP_W + 1;
   localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((2 ** (PIX_W - 1)) - 1);
   localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(2 ** (PIX_W - 1));

   if (IN_INT_W < KEEP_W + 1) begin : g_bad_int
      $error("chroma_round_clip: IN_INT_W too small for the full-range field");
   end
   if (IN_FRAC_W < 1) begin : g_bad_frac
      $error("chroma_round_clip: at least one fractional bit is needed");
   end

   logic signed [KEEP_W-1:0] fld_norm, fld_full, fld;
   logic                     rb_norm, rb_full, rnd_bit;
   logic signed [SUM_W-1:0]  sum;
   logic                     unused_bits;

   // normalised: integer LSBs, round on top fraction bit
   assign fld_norm = din[IN_FRAC_W +: KEEP_W];
   assign rb_norm  = din[IN_FRAC_W-1];
   // full range: one integer bit higher, round on integer LSB
   assign fld_full = din[IN_FRAC_W+1 +: KEEP_W];
   assign rb_full  = din[IN_FRAC_W];

   assign fld         = norm ? fld_norm : fld_full;
   assign rnd_bit     = norm ? rb_norm  : rb_full;
   assign sum         = {fld[KEEP_W-1], fld} + SUM_W'(rnd_bit);
   assign unused_bits = ^din;

   always_comb begin
      if (sum > MAX_V)      dout = MAX_V[PIX_W-1:0];
      else if (sum < MIN_V) dout = MIN_V[PIX_W-1:0];
      else                  dout = sum[PIX_W-1:0];
   end
endmodule

// File: rtl/range_limiter.sv
module range_limiter
   import pix_fmt_pkg::*;
#(
   parameter int PIX_W      = 8,
   parameter bit IS_CHROMA  = 1'b0,
   parameter int LO_STUDIO  = 16,
   parameter int HI_STUDIO  = 235,
   parameter int LO_WIDE    = 1,
   parameter int HI_WIDE    = 254
) (
   input  logic [PIX_W-1:0] din,
   input  logic             bypass,
   input  logic             sel,
   output logic [PIX_W-1:0] dout
);
   localparam logic [PIX_W-1:0] LO_S = PIX_W'(LO_STUDIO);
   localparam logic [PIX_W-1:0] HI_S = PIX_W'(HI_STUDIO);
   localparam logic [PIX_W-1:0] LO_W = PIX_W'(LO_WIDE);
   localparam logic [PIX_W-1:0] HI_W = PIX_W'(HI_WIDE);

   if (LO_STUDIO > HI_STUDIO || LO_WIDE > HI_WIDE) begin : g_bad_order
      $error("range_limiter: lower limit above upper limit");
   end
   if (HI_STUDIO >= 2 ** PIX_W || HI_WIDE >= 2 ** PIX_W) begin : g_bad_span
      $error("range_limiter: limit does not fit the pixel width");
   end

   logic [PIX_W-1:0] shifted;
   limit_kind_e      kind;

   if (IS_CHROMA) begin : g_offset
      // +half scale on a two's complement byte flips its sign bit
      assign shifted = {~din[PIX_W-1], din[PIX_W-2:0]};
   end else begin : g_plain
      assign shifted = din;
   end

   assign kind = pick_limit(bypass, sel);

   always_comb begin
      unique case (kind)
         LIM_WIDE:   dout = (shifted < LO_W) ? LO_W : (shifted > HI_W) ? HI_W : shifted;
         LIM_STUDIO: dout = (shifted < LO_S) ? LO_S : (shifted > HI_S) ? HI_S : shifted;
         default:    dout = din;
      endcase
   end
endmodule

// File: rtl/pix_out_formatter.sv
module pix_out_formatter #(
   parameter int IN_INT_W        = 15,
   parameter int IN_FRAC_W       = 3,
   parameter int PIX_W           = 8,
   parameter int LUMA_LO_STUDIO  = 16,
   parameter int LUMA_HI_STUDIO  = 235,
   parameter int CHR_LO_STUDIO   = 16,
   parameter int CHR_HI_STUDIO   = 240,
   parameter int WIDE_LO         = 1,
   parameter int WIDE_HI         = 254
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic                          ctl_norm,
   input  logic                          ctl_sel,
   input  logic                          ctl_bypass,
   input  logic [IN_INT_W+IN_FRAC_W-1:0] luma_in,
   input  logic [IN_INT_W+IN_FRAC_W-1:0] cha_in,
   input  logic [IN_INT_W+IN_FRAC_W-1:0] chb_in,
   output logic                          out_valid,
   output logic [PIX_W-1:0]              luma_out,
   output logic [PIX_W-1:0]              cha_out,
   output logic [PIX_W-1:0]              chb_out
);
   localparam int IN_W       = IN_INT_W + IN_FRAC_W;
   localparam int NUM_CHROMA = 2;

   if (PIX_W < 2) begin : g_bad_pix
      $error("pix_out_formatter: PIX_W must be at least 2");
   end

   logic [IN_W-1:0]  ch_in   [NUM_CHROMA];
   logic [PIX_W-1:0] ch_clip [NUM_CHROMA];
   logic [PIX_W-1:0] ch_fmt  [NUM_CHROMA];
   logic [PIX_W-1:0] ch_q    [NUM_CHROMA];
   logic [PIX_W-1:0] luma_clip, luma_fmt;

   assign ch_in[0] = cha_in;
   assign ch_in[1] = chb_in;

   luma_round_clip #(
      .IN_INT_W (IN_INT_W),
      .IN_FRAC_W(IN_FRAC_W),
      .PIX_W    (PIX_W)
   ) i_luma_clip (
      .din (luma_in),
      .dout(luma_clip)
   );

   range_limiter #(
      .PIX_W    (PIX_W),
      .IS_CHROMA(1'b0),
      .LO_STUDIO(LUMA_LO_STUDIO),
      .HI_STUDIO(LUMA_HI_STUDIO),
      .LO_WIDE  (WIDE_LO),
      .HI_WIDE  (WIDE_HI)
   ) i_luma_lim (
      .din   (luma_clip),
      .bypass(ctl_bypass),
      .sel   (ctl_sel),
      .dout  (luma_fmt)
   );

   for (genvar c = 0; c < NUM_CHROMA; c++) begin : g_chroma
      chroma_round_clip #(
         .IN_INT_W (IN_INT_W),
         .IN_FRAC_W(IN_FRAC_W),
         .PIX_W    (PIX_W)
      ) i_clip (
         .din (ch_in[c]),
         .norm(ctl_norm),
         .dout(ch_clip[c])
      );

      range_limiter #(
         .PIX_W    (PIX_W),
         .IS_CHROMA(1'b1),
         .LO_STUDIO(CHR_LO_STUDIO),
         .HI_STUDIO(CHR_HI_STUDIO),
         .LO_WIDE  (WIDE_LO),
         .HI_WIDE  (WIDE_HI)
      ) i_lim (
         .din   (ch_clip[c]),
         .bypass(ctl_bypass),
         .sel   (ctl_sel),
         .dout  (ch_fmt[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ch_q[c] <= '0;
         else        ch_q[c] <= ch_fmt[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         luma_out  <= '0;
      end else begin
         out_valid <= in_valid;
         luma_out  <= luma_fmt;
      end
   end

   assign cha_out = ch_q[0];
   assign chb_out = ch_q[1];

   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                              // R8
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                            // R8
   AST_WIDE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_bypass && ctl_sel && in_valid) |=>
         (luma_out >= PIX_W'(WIDE_LO) && luma_out <= PIX_W'(WIDE_HI) &&
          cha_out  >= PIX_W'(WIDE_LO) && cha_out  <= PIX_W'(WIDE_HI) &&
          chb_out  >= PIX_W'(WIDE_LO) && chb_out  <= PIX_W'(WIDE_HI)));     // R6
   AST_STUDIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_bypass && !ctl_sel && in_valid) |=>
         (luma_out >= PIX_W'(LUMA_LO_STUDIO) && luma_out <= PIX_W'(LUMA_HI_STUDIO) &&
          cha_out  >= PIX_W'(CHR_LO_STUDIO)  && cha_out  <= PIX_W'(CHR_HI_STUDIO) &&
          chb_out  >= PIX_W'(CHR_LO_STUDIO)  && chb_out  <= PIX_W'(CHR_HI_STUDIO))); // R7
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(luma_in) && $stable(ctl_bypass) && $stable(ctl_sel) && $past(rst_n)
         |=> $stable(luma_out));                                            // R8
endmodule

// File: tb/test_pix_out_formatter.sv
module test_pix_out_formatter;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        ctl_norm = 1'b1, ctl_sel = 1'b1, ctl_bypass = 1'b1;
   logic [17:0] luma_in = '0, cha_in = '0, chb_in = '0;
   logic        out_valid;
   logic [7:0]  luma_out, cha_out, chb_out;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   pix_out_formatter i_pix_out_formatter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .ctl_norm(ctl_norm), .ctl_sel(ctl_sel), .ctl_bypass(ctl_bypass),
      .luma_in(luma_in), .cha_in(cha_in), .chb_in(chb_in),
      .out_valid(out_valid), .luma_out(luma_out),
      .cha_out(cha_out), .chb_out(chb_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic [17:0] mk(int ip, int fr);
      return 18'((ip * 8) + fr);
   endfunction

   function automatic int clampi(int v, int lo, int hi);
      return (v < lo) ? lo : (v > hi) ? hi : v;
   endfunction

   function automatic int ref_luma(logic [17:0] x, logic byp, logic sel);
      int v;
      v = clampi(int'($signed(x[12:3])) + int'(x[2]), 0, 255);
      if (byp)      return v;
      else if (sel) return clampi(v, 1, 254);
      else          return clampi(v, 16, 235);
   endfunction

   function automatic int ref_chroma(logic [17:0] x, logic norm, logic byp, logic sel);
      int v;
      if (norm) v = int'($signed(x[11:3])) + int'(x[2]);
      else      v = int'($signed(x[12:4])) + int'(x[3]);
      v = clampi(v, -128, 127);
      if (byp)      return v & 255;
      v = v + 128;
      if (sel)      return clampi(v, 1, 254);
      else          return clampi(v, 16, 240);
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_ctl(logic norm, logic sel, logic byp);
      ctl_norm = norm; ctl_sel = sel; ctl_bypass = byp;
   endtask

   // drive at negedge, capture at posedge, sample at following negedge
   task automatic run_vec(string tag, logic [17:0] l, logic [17:0] a, logic [17:0] b);
      @(negedge clk);
      luma_in = l; cha_in = a; chb_in = b; in_valid = 1'b1;
      @(negedge clk);
      chk({tag, " luma"}, int'(luma_out), ref_luma(l, ctl_bypass, ctl_sel));
      chk({tag, " cha"}, int'(cha_out), ref_chroma(a, ctl_norm, ctl_bypass, ctl_sel));
      chk({tag, " chb"}, int'(chb_out), ref_chroma(b, ctl_norm, ctl_bypass, ctl_sel));
   endtask

   task automatic t_reset();
      luma_in = mk(100, 0); cha_in = mk(50, 0); chb_in = mk(-50, 0); in_valid = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 out_valid", int'(out_valid), 0);
      chk("R9 luma", int'(luma_out), 0);
      chk("R9 cha", int'(cha_out), 0);
      chk("R9 chb", int'(chb_out), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_luma();
      set_ctl(1'b1, 1'b1, 1'b1);
      run_vec("R1 round up", mk(100, 4), mk(0, 0), mk(0, 0));
      chk("R1 round up literal", int'(luma_out), 101);
      run_vec("R1 round down", mk(100, 3), mk(1, 0), mk(2, 0));
      run_vec("R1 negative", mk(-3, 7), mk(0, 0), mk(0, 0));
      chk("R1 negative literal", int'(luma_out), 0);
      run_vec("R1 high", mk(255, 4), mk(0, 0), mk(0, 0));
      run_vec("R1 top dropped", mk(1024 + 77, 0), mk(0, 0), mk(0, 0));
      chk("R1 top dropped literal", int'(luma_out), 77);
      run_vec("R1 no wrap", mk(511, 4), mk(0, 0), mk(0, 0));
      chk("R1 no wrap literal", int'(luma_out), 255);
   endtask

   task automatic t_chroma_norm();
      set_ctl(1'b1, 1'b1, 1'b1);
      run_vec("R2 round", mk(9, 0), mk(-5, 4), mk(37, 3));
      chk("R2 literal", int'(cha_out), 8'hFC);
      run_vec("R2 round up", mk(9, 0), mk(20, 7), mk(-1, 0));
      run_vec("R4 clip high", mk(9, 0), mk(127, 4), mk(300, 0));
      chk("R4 clip high literal", int'(cha_out), 127);
      run_vec("R4 clip low", mk(9, 0), mk(-200, 0), mk(-128, 0));
      chk("R4 clip low literal", int'(cha_out), 128);
   endtask

   task automatic t_chroma_full();
      set_ctl(1'b0, 1'b1, 1'b1);
      run_vec("R3 odd", mk(9, 0), mk(51, 0), mk(50, 7));
      chk("R3 odd literal", int'(cha_out), 26);
      run_vec("R3 neg", mk(9, 0), mk(-51, 0), mk(-2, 0));
      run_vec("R3 R4 no wrap", mk(9, 0), mk(255, 0), mk(-300, 0));
      chk("R3 no wrap literal", int'(cha_out), 127);
   endtask

   task automatic t_offset();
      set_ctl(1'b1, 1'b1, 1'b0);
      run_vec("R5 zero", mk(100, 0), mk(0, 0), mk(-3, 0));
      chk("R5 zero literal", int'(cha_out), 128);
      run_vec("R5 pos", mk(100, 0), mk(40, 0), mk(-40, 0));
   endtask

   task automatic t_wide();
      set_ctl(1'b1, 1'b1, 1'b0);
      run_vec("R6 low", mk(0, 0), mk(-128, 0), mk(-200, 0));
      chk("R6 luma low literal", int'(luma_out), 1);
      chk("R6 chroma low literal", int'(cha_out), 1);
      run_vec("R6 high", mk(255, 0), mk(127, 0), mk(100, 0));
      chk("R6 luma high literal", int'(luma_out), 254);
      run_vec("R6 carry", mk(254, 4), mk(127, 4), mk(126, 4));
      chk("R6 carry literal", int'(cha_out), 254);
   endtask

   task automatic t_studio();
      set_ctl(1'b1, 1'b0, 1'b0);
      run_vec("R7 low", mk(5, 0), mk(-120, 0), mk(0, 0));
      chk("R7 luma low literal", int'(luma_out), 16);
      run_vec("R7 high", mk(250, 0), mk(120, 0), mk(112, 0));
      chk("R7 chroma high literal", int'(cha_out), 240);
      run_vec("R7 carry", mk(254, 4), mk(127, 4), mk(111, 4));
      chk("R7 carry luma literal", int'(luma_out), 235);
      set_ctl(1'b0, 1'b0, 1'b0);
      run_vec("R7 full range", mk(16, 0), mk(-255, 0), mk(225, 0));
   endtask

   task automatic t_pipe();
      set_ctl(1'b1, 1'b1, 1'b1);
      @(negedge clk);
      luma_in = mk(10, 0); cha_in = mk(1, 0); chb_in = mk(2, 0); in_valid = 1'b0;
      @(negedge clk);
      chk("R8 valid low", int'(out_valid), 0);
      chk("R8 data", int'(luma_out), 10);
      luma_in = mk(77, 0); in_valid = 1'b1;
      #1;
      chk("R8 no early change", int'(luma_out), 10);
      chk("R8 valid still low", int'(out_valid), 0);
      @(negedge clk);
      chk("R8 valid high", int'(out_valid), 1);
      chk("R8 new data", int'(luma_out), 77);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R8 valid drop", int'(out_valid), 0);
   endtask

   initial begin
      t_reset();
      t_luma();
      t_chroma_norm();
      t_chroma_full();
      t_offset();
      t_wide();
      t_studio();
      t_pipe();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule